// File: doc/BRIEF.md
# Page-Bounded String Transfer Chunker

The chunker sits beside a string I/O engine and decides how many 16-bit words a repeated port transfer may move as a single burst without crossing the 4 KiB page that holds its first word. On a start pulse it looks at the segment offset, the linear address, the scaled segment limit, the access rights of the segment, a host-access grant, the direction flag and the requested word count. From these it grants a burst length. A grant of zero means the caller must fall back to the slow path.

When the grant is non-zero, the block steps through the burst at one word per cycle. It presents the address of the current word, then advances it by two bytes up or down. An asynchronous event ends the burst after the word of that cycle. A one-cycle done pulse follows, and the count of words actually moved is valid with it.

Top module: `page_burst_chunker`

## Requirements
- R1: The grant is zero when the segment lacks the right needed by the transfer: write permission for an input transfer (`xfer_in_i`=1), read permission for an output transfer (`xfer_in_i`=0). The other right has no effect.
- R2: The grant is zero when the segment offset with bits [11:0] forced to one is greater than the scaled segment limit.
- R3: The grant is zero when bit 0 of the linear address is set.
- R4: The grant is zero when `host_ok_i` is low.
- R5: With `desc_i`=0, the words that fit are (4096 − lin_addr[11:0]) / 2, and the address advances by +2 per word.
- R6: With `desc_i`=1, the words that fit are (2 + lin_addr[11:0]) / 2, and the address advances by −2 per word.
- R7: The grant is the smaller of the requested count and the words that fit, so it never exceeds 2048. A request of zero grants zero.
- R8: When `async_evt_i` is high in a cycle where `step_o` is high, that word completes and no further word follows. `cnt_o` then reports the number of words moved.
- R9: `step_o` is high for exactly one cycle per word. The first word comes in the cycle after the accepted start, and its `ptr_o` equals the linear address. `done_o` is a one-cycle pulse in the cycle after the last word, or in the cycle after start when the grant is zero. `cnt_o` is valid with `done_o`.
- R10: A start pulse while `busy_o` is high is ignored, and the burst in flight is unchanged.
- R11: After reset, `busy_o`, `step_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate and launch a burst |
| xfer_in_i | input | 1 | 1 = input transfer (port to memory), 0 = output |
| seg_wr_ok_i | input | 1 | Segment is writable |
| seg_rd_ok_i | input | 1 | Segment is readable |
| seg_off_i | input | 32 | Segment offset of the first word |
| lin_addr_i | input | 32 | Linear address of the first word |
| seg_limit_i | input | 32 | Scaled segment limit |
| host_ok_i | input | 1 | Direct host access granted for the page |
| desc_i | input | 1 | Direction flag, 1 = descending |
| req_cnt_i | input | 32 | Requested word count |
| async_evt_i | input | 1 | Asynchronous event, ends the burst |
| busy_o | output | 1 | Burst in progress or completing |
| step_o | output | 1 | A word moves this cycle |
| ptr_o | output | 32 | Address of the current word |
| done_o | output | 1 | Completion pulse |
| cnt_o | output | 32 | Words moved, valid with done_o |

## Verification
The assertions check the timing properties on every cycle:
- done is a single-cycle pulse and never coincides with a step;
- each consecutive step moves the pointer by two bytes in the latched direction;
- an event during a step is followed by done;
- the reported count equals the steps seen and never exceeds half a page.

The decline conditions, the ascending and descending page-fit arithmetic, the clamp against the requested count and the ignored mid-burst start can only be shown by the bench's scenarios. These compare the granted count and the first and last word addresses with a model.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/pbc_chunk_eval.sv
module pbc_chunk_eval #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              xfer_in_i,
  input  logic              seg_wr_ok_i,
  input  logic              seg_rd_ok_i,
  input  logic [ADDR_W-1:0] seg_off_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic [ADDR_W-1:0] seg_limit_i,
  input  logic              host_ok_i,
  input  logic              desc_i,
  input  logic [CNT_W-1:0]  req_cnt_i,
  output logic [CNT_W-1:0]  grant_o
);
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int FIT_W      = PAGE_BITS + 1;

  logic [PAGE_BITS-1:0] page_off;
  logic [FIT_W-1:0]     span_up, span_dn, span;
  logic [CNT_W-1:0]     fit_words;
  logic                 perm_ok, limit_bad, decline;

  assign page_off  = lin_addr_i[PAGE_BITS-1:0];
  assign span_up   = FIT_W'(PAGE_BYTES) - FIT_W'(page_off);
  assign span_dn   = FIT_W'(page_off) + FIT_W'(2);
  assign span      = desc_i ? span_dn : span_up;
  assign fit_words = CNT_W'(span >> 1);

  assign perm_ok   = xfer_in_i ? seg_wr_ok_i : seg_rd_ok_i;
  // whole page past the offset must sit inside the limit
  assign limit_bad = (seg_off_i | ADDR_W'(PAGE_BYTES - 1)) > seg_limit_i;
  assign decline   = !perm_ok || limit_bad || lin_addr_i[0] || !host_ok_i;

  always_comb begin
    if (decline)                    grant_o = '0;
    else if (req_cnt_i < fit_words) grant_o = req_cnt_i;
    else                            grant_o = fit_words;
  end
endmodule

// File: rtl/pbc_burst_stepper.sv
module pbc_burst_stepper
  import pbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [CNT_W-1:0]  grant_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic              desc_i,
  input  logic              async_evt_i,
  output logic              busy_o,
  output logic              step_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

  run_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  moved_q, grant_q, moved_nxt;
  logic              desc_q;

  assign moved_nxt = moved_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      moved_q <= '0;
      grant_q <= '0;
      desc_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          grant_q <= grant_i;
          ptr_q   <= lin_addr_i;
          desc_q  <= desc_i;
          moved_q <= '0;
          state_q <= (grant_i == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          moved_q <= moved_nxt;
          ptr_q   <= desc_q ? ptr_q - WORD_STEP : ptr_q + WORD_STEP;
          if (moved_nxt == grant_q || async_evt_i) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign step_o = state_q == ST_RUN;
  assign done_o = state_q == ST_DONE;
  assign ptr_o  = ptr_q;
  assign cnt_o  = done_o ? moved_q : '0;
endmodule

// File: rtl/page_burst_chunker.sv
module page_burst_chunker #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              xfer_in_i,
  input  logic              seg_wr_ok_i,
  input  logic              seg_rd_ok_i,
  input  logic [ADDR_W-1:0] seg_off_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic [ADDR_W-1:0] seg_limit_i,
  input  logic              host_ok_i,
  input  logic              desc_i,
  input  logic [CNT_W-1:0]  req_cnt_i,
  input  logic              async_evt_i,
  output logic              busy_o,
  output logic              step_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] grant;
  logic             launch;

  assign launch = start_i && !busy_o;

  pbc_chunk_eval #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)) u_eval (
    .xfer_in_i   (xfer_in_i),
    .seg_wr_ok_i (seg_wr_ok_i),
    .seg_rd_ok_i (seg_rd_ok_i),
    .seg_off_i   (seg_off_i),
    .lin_addr_i  (lin_addr_i),
    .seg_limit_i (seg_limit_i),
    .host_ok_i   (host_ok_i),
    .desc_i      (desc_i),
    .req_cnt_i   (req_cnt_i),
    .grant_o     (grant)
  );

  pbc_burst_stepper #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .grant_i     (grant),
    .lin_addr_i  (lin_addr_i),
    .desc_i      (desc_i),
    .async_evt_i (async_evt_i),
    .busy_o      (busy_o),
    .step_o      (step_o),
    .ptr_o       (ptr_o),
    .done_o      (done_o),
    .cnt_o       (cnt_o)
  );
endmodule

// File: rtl/page_burst_chunker_chk.sv
module page_burst_chunker_chk #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int PAGE_BITS = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              desc_i,
  input logic              async_evt_i,
  input logic              busy_o,
  input logic              step_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] MAX_WORDS = CNT_W'((1 << PAGE_BITS) / 2);

  logic             dir_q;
  logic [CNT_W-1:0] steps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= 1'b0;
      steps_q <= '0;
    end else if (start_i && !busy_o) begin
      dir_q   <= desc_i;
      steps_q <= '0;
    end else if (step_o) begin
      steps_q <= steps_q + CNT_W'(1);
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  step_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_o && done_o));
  // R5 R6
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && $past(step_o)) |->
      ptr_o == ($past(dir_q) ? $past(ptr_o) - ADDR_W'(2) : $past(ptr_o) + ADDR_W'(2)));
  // R8
  evt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && async_evt_i) |=> done_o);
  // R7
  page_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_o <= MAX_WORDS);
  // R9
  cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_o == steps_q);
endmodule

bind page_burst_chunker page_burst_chunker_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .desc_i      (desc_i),
  .async_evt_i (async_evt_i),
  .busy_o      (busy_o),
  .step_o      (step_o),
  .ptr_o       (ptr_o),
  .done_o      (done_o),
  .cnt_o       (cnt_o)
);

// File: tb/page_burst_chunker_bench.sv
module page_burst_chunker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, xfer_in_i = 1'b0, seg_wr_ok_i = 1'b0, seg_rd_ok_i = 1'b0;
  logic [31:0] seg_off_i = '0, lin_addr_i = '0, seg_limit_i = '0, req_cnt_i = '0;
  logic        host_ok_i = 1'b0, desc_i = 1'b0, async_evt_i = 1'b0;
  logic        busy_o, step_o, done_o;
  logic [31:0] ptr_o, cnt_o;

  always #10 clk_i = ~clk_i;

  page_burst_chunker u_page_burst_chunker (.*);

  typedef struct {
    string       tag;
    logic [31:0] cnt;
    logic [31:0] first;
    logic [31:0] last;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0, cycles = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int unsigned model(bit xin, bit wr, bit rd, logic [31:0] soff,
      logic [31:0] lin, logic [31:0] lim, bit host, bit desc, int unsigned req);
    int unsigned fit;
    if (xin ? !wr : !rd) return 0;
    if ((soff | 32'h0000_0FFF) > lim) return 0;
    if (lin[0]) return 0;
    if (!host) return 0;
    fit = desc ? (2 + int'(lin[11:0])) / 2 : (4096 - int'(lin[11:0])) / 2;
    return (req < fit) ? req : fit;
  endfunction

  task automatic run(string tag, bit xin, bit wr, bit rd, logic [31:0] soff,
      logic [31:0] lin, logic [31:0] lim, bit host, bit desc, int unsigned req,
      int evt_at, int relaunch_at);
    exp_t e;
    int   idx = 0;
    int unsigned g = model(xin, wr, rd, soff, lin, lim, host, desc, req);
    if (evt_at >= 0 && evt_at < int'(g)) g = evt_at + 1;
    e.tag = tag; e.cnt = g; e.first = lin;
    e.last = desc ? lin - 32'(2 * (g - 1)) : lin + 32'(2 * (g - 1));
    q.push_back(e);
    @(negedge clk_i);
    xfer_in_i = xin; seg_wr_ok_i = wr; seg_rd_ok_i = rd; seg_off_i = soff;
    lin_addr_i = lin; seg_limit_i = lim; host_ok_i = host; desc_i = desc;
    req_cnt_i = req; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    forever begin
      if (done_o) break;
      async_evt_i = step_o && (idx == evt_at);
      start_i     = step_o && (idx == relaunch_at);
      lin_addr_i  = (step_o && idx == relaunch_at) ? lin ^ 32'h0000_0100 : lin;
      desc_i      = (step_o && idx == relaunch_at) ? !desc : desc;
      if (step_o) idx++;
      @(negedge clk_i);
    end
    async_evt_i = 1'b0; start_i = 1'b0; lin_addr_i = lin; desc_i = desc;
  endtask

  // monitor / scoreboard
  int          nsteps = 0;
  logic [31:0] first_p = '0, last_p = '0;
  bit          prev_step = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (step_o) begin
        if (nsteps == 0) first_p = ptr_o;
        last_p = ptr_o;
        nsteps++;
      end
      if (done_o) begin
        exp_t e;
        if (q.size() == 0) begin
          check("R9 unexpected done", 32'd1, 32'd0);
        end else begin
          e = q.pop_front();
          check({e.tag, " cnt"}, cnt_o, e.cnt);
          check({e.tag, " R9 steps"}, 32'(nsteps), e.cnt);
          if (e.cnt != 0) begin
            check({e.tag, " R9 first ptr"}, first_p, e.first);
            check({e.tag, " last ptr"}, last_p, e.last);
            check({e.tag, " R9 done after last word"}, 32'(prev_step), 32'd1);
          end
        end
        nsteps = 0;
      end
      prev_step = step_o;
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      finish_run();
    end
  end

  localparam logic [31:0] BIG = 32'hFFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 busy", 32'(busy_o), 0);
    check("R11 step", 32'(step_o), 0);
    check("R11 done", 32'(done_o), 0);
    //  tag                    xin wr rd soff          lin           lim  host desc req  evt rel
    run("R5 asc page start",   1, 1, 0, 32'h0000_0000, 32'h0001_0000, BIG, 1, 0, 10,   -1, -1);
    run("R5 asc near end",     1, 1, 0, 32'h0000_0010, 32'h0001_1FFA, BIG, 1, 0, 100,  -1, -1);
    run("R6 desc small off",   0, 0, 1, 32'h0000_0020, 32'h0002_1004, BIG, 1, 1, 100,  -1, -1);
    run("R6 desc page base",   0, 0, 1, 32'h0000_0020, 32'h0002_2000, BIG, 1, 1, 5,    -1, -1);
    run("R7 zero request",     1, 1, 1, 32'h0000_0000, 32'h0000_4000, BIG, 1, 0, 0,    -1, -1);
    run("R7 clamp full page",  1, 1, 1, 32'h0000_0000, 32'h0000_5000, BIG, 1, 0, 5000, -1, -1);
    run("R7 clamp desc",       0, 1, 1, 32'h0000_0000, 32'h0000_6FFE, BIG, 1, 1, 9000, -1, -1);
    run("R3 misaligned",       1, 1, 1, 32'h0000_0000, 32'h0000_3001, BIG, 1, 0, 8,    -1, -1);
    run("R1 in no write",      1, 0, 1, 32'h0000_0000, 32'h0000_7000, BIG, 1, 0, 8,    -1, -1);
    run("R1 out no read",      0, 1, 0, 32'h0000_0000, 32'h0000_7000, BIG, 1, 0, 8,    -1, -1);
    run("R1 out read only",    0, 0, 1, 32'h0000_0000, 32'h0000_7000, BIG, 1, 0, 8,    -1, -1);
    run("R2 limit short",      1, 1, 1, 32'h0000_1234, 32'h0000_8000, 32'h0000_1FFE, 1, 0, 4, -1, -1);
    run("R2 limit exact",      1, 1, 1, 32'h0000_1234, 32'h0000_8000, 32'h0000_1FFF, 1, 0, 4, -1, -1);
    run("R4 host denied",      1, 1, 1, 32'h0000_0000, 32'h0000_9000, BIG, 0, 0, 8,    -1, -1);
    run("R8 event mid burst",  1, 1, 1, 32'h0000_0000, 32'h0000_A100, BIG, 1, 0, 10,    2, -1);
    run("R8 event first word", 0, 1, 1, 32'h0000_0000, 32'h0000_A200, BIG, 1, 1, 10,    0, -1);
    run("R10 start while busy",1, 1, 1, 32'h0000_0000, 32'h0000_B000, BIG, 1, 0, 6,    -1, 1);
    repeat (3) @(negedge clk_i);
    check("R9 all results seen", 32'(q.size()), 0);
    finish_run();
  end
endmodule